// File: doc/BRIEF.md
# Programmable Down-Counting Counter/Timer

This block is a 16-bit down-counter that sits behind a byte-wide register bus inside a serial-port peripheral. Software loads a 16-bit reload value one byte at a time. A read of one address starts the unit and a read of another stops it; the data returned by those reads carries no meaning and is driven as zero. Counting advances only on cycles where the clock-enable input `tick_i` is high. Clock-source selection happens outside this block.

The `timer_i` input selects the mode. With `timer_i` low the unit is a one-shot countdown. It raises a ready flag and pulls its waveform low at terminal count, and software can read the live count back. With `timer_i` high it is a free-running square-wave generator whose half-period is the reload value in ticks. A stop command in that mode only clears the ready flag and leaves the timer running. The ready flag feeds bit 3 of the interrupt status, and the waveform feeds one multi-purpose output pin.

Top module: `ctmr`

## Requirements
- R1: After reset `wave_o` is 1, `ready_o` is 0, the unit is stopped, and the reload value and count are 0.
- R2: Writing address 0 loads the upper reload byte and writing address 1 loads the lower reload byte. In counter mode, reading address 2 returns the upper count byte and reading address 3 returns the lower count byte.
- R3: Reading address 4 (start) loads the count from the reload value and runs the unit. In counter mode each tick then lowers the count by one. Reads of addresses 4 and 5 return 0.
- R4: In counter mode, the tick that takes the count from 1 to 0 sets `ready_o` and drives `wave_o` low. The count then wraps to 0xFFFF and keeps counting down.
- R5: In counter mode, reading address 5 (stop) halts the count and holds its value. It also drives `wave_o` high and clears `ready_o`.
- R6: In counter mode, reload writes made while the unit is running leave the running count unchanged. The next start uses the new value.
- R7: In timer mode, `wave_o` is high after start and toggles each time the count is reloaded, once every reload-value ticks. `ready_o` sets on each low-to-high toggle, which marks one full period.
- R8: In timer mode, a stop command clears `ready_o` only. The count keeps running and `wave_o` keeps toggling.
- R9: In timer mode, a reload write takes effect at the end of the current half-period. That half-period completes with its old length.
- R10: In timer mode, every read returns 0, including reads of the count addresses.
- R11: Start and stop take priority over a tick in the same cycle. With `tick_i` low and no start, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| timer_i | input | 1 | Mode select: 1 timer, 0 counter |
| we_i | input | 1 | Bus write strobe |
| re_i | input | 1 | Bus read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| wave_o | output | 1 | Output waveform for the multi-purpose pin |
| ready_o | output | 1 | Counter-ready status |

## Verification
The hardest situation to reach is a timer-mode reload change landing in the middle of a half-period. Seeing it needs the bench to know the exact tick on which the old half-period ends. The bench therefore restarts the timer from a known reload value, counts single ticks, writes the new value partway through, and checks `wave_o` tick by tick across both the old and the new half-period lengths. The counter-mode wrap past zero is reached with a small reload value followed by one extra tick. The count is then read back after a stop.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef struct packed {
    logic start;
    logic stop;
  } cmd_t;

  function automatic int pre_addr(int nb, int lane);
    return nb - 1 - lane;
  endfunction

  function automatic int cur_addr(int nb, int lane);
    return 2 * nb - 1 - lane;
  endfunction

  function automatic int start_addr(int nb);
    return 2 * nb;
  endfunction

  function automatic int stop_addr(int nb);
    return 2 * nb + 1;
  endfunction
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  preload_o,
  output cmd_t              cmd_o
);
  localparam int NB = CNT_W / DATA_W;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic              hit;
    logic [DATA_W-1:0] lane_q;
    assign hit = we_i && (addr_i == ADDR_W'(pre_addr(NB, b)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  lane_q <= '0;
      else if (hit) lane_q <= wdata_i;
    end
    assign preload_o[b*DATA_W +: DATA_W] = lane_q;
  end

  // commands are side effects of reads
  assign cmd_o.start = re_i && (addr_i == ADDR_W'(start_addr(NB)));
  assign cmd_o.stop  = re_i && (addr_i == ADDR_W'(stop_addr(NB)));
endmodule

// File: rtl/ctmr_rdmux.sv
module ctmr_rdmux
  import ctmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              re_i,
  input  logic              timer_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NB = CNT_W / DATA_W;

  always_comb begin
    rdata_o = '0;
    if (re_i && !timer_i) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(cur_addr(NB, b))) rdata_o = cnt_i[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             timer_i,
  input  cmd_t             cmd_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             wave_o,
  output logic             ready_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last;
  assign last = (cnt_o == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      run_o   <= 1'b0;
      wave_o  <= 1'b1;
      ready_o <= 1'b0;
    end else if (cmd_i.start) begin
      cnt_o  <= preload_i;
      run_o  <= 1'b1;
      wave_o <= 1'b1;
    end else if (cmd_i.stop) begin
      ready_o <= 1'b0;
      if (!timer_i) begin
        run_o  <= 1'b0;
        wave_o <= 1'b1;
      end
    end else if (run_o && tick_i) begin
      if (timer_i) begin
        if (last) begin
          cnt_o  <= preload_i;  // new reload applies at half-period edge
          wave_o <= ~wave_o;
          if (!wave_o) ready_o <= 1'b1;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end else begin
        cnt_o <= cnt_o - ONE;  // wraps past zero
        if (last) begin
          ready_o <= 1'b1;
          wave_o  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctmr.sv
module ctmr
  import ctmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              timer_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wave_o,
  output logic              ready_o
);
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  cmd_t             cmd;

  ctmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i,
    .preload_o(preload), .cmd_o(cmd)
  );

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .timer_i,
    .cmd_i(cmd), .preload_i(preload),
    .cnt_o(cnt_q), .run_o(run_q), .wave_o, .ready_o
  );

  ctmr_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdmux (
    .re_i, .timer_i, .addr_i, .cnt_i(cnt_q), .rdata_o
  );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              timer_i,
  input logic              re_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wave_o,
  input logic              ready_o,
  input logic              start,
  input logic              stop,
  input logic              run_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  preload
);
  // R5
  cnt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !start && !timer_i) |=> (wave_o && !ready_o && !run_q));

  // R8
  tmr_stop_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !start && timer_i && run_q) |=> (run_q && !ready_o));

  // R10
  tmr_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && timer_i) |-> (rdata_o == '0));

  // R3
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && tick_i && !start && !stop && !timer_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !start) |=> $stable(cnt_q));

  // R6
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == $past(preload)));

  // R4
  ready_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(tick_i));

  // R7
  tmr_ready_wave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ready_o) && timer_i) |-> $rose(wave_o));
endmodule

bind ctmr ctmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .timer_i(timer_i),
  .re_i(re_i), .rdata_o(rdata_o), .wave_o(wave_o), .ready_o(ready_o),
  .start(cmd.start), .stop(cmd.stop), .run_q(run_q), .cnt_q(cnt_q),
  .preload(preload)
);

// File: tb/ctmr_test.sv
module ctmr_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       timer_i = 1'b0;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wave_o;
  logic       ready_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk_i = ~clk_i;

  ctmr uut (
    .clk_i, .rst_ni, .tick_i, .timer_i, .we_i, .re_i,
    .addr_i, .wdata_i, .rdata_o, .wave_o, .ready_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    re_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] hi, lo;
    rd(3'd2, hi);
    rd(3'd3, lo);
    v = {hi, lo};
  endtask

  task automatic set_pre(logic [15:0] v);
    wr(3'd0, v[15:8]);
    wr(3'd1, v[7:0]);
  endtask

  task automatic ticks(int n);
    @(negedge clk_i);
    tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic start_cmd(output logic [7:0] d);
    rd(3'd4, d);
  endtask

  task automatic stop_cmd(output logic [7:0] d);
    rd(3'd5, d);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 wave", wave_o, 1);
    chk("R1 ready", ready_o, 0);
    rd16(v);
    chk("R1 count", v, 0);
    ticks(3);
    rd16(v);
    chk("R1 stopped", v, 0);
  endtask

  task automatic t_bytes;
    logic [15:0] v;
    logic [7:0]  d;
    set_pre(16'hABCD);
    start_cmd(d);
    chk("R3 start data", d, 0);
    rd16(v);
    chk("R2 byte lanes", v, 16'hABCD);
    ticks(2);
    rd16(v);
    chk("R3 countdown", v, 16'hABCB);
    stop_cmd(d);
    chk("R3 stop data", d, 0);
  endtask

  task automatic t_terminal;
    logic [15:0] v;
    logic [7:0]  d;
    set_pre(16'h0005);
    start_cmd(d);
    ticks(4);
    chk("R4 before tc wave", wave_o, 1);
    chk("R4 before tc ready", ready_o, 0);
    ticks(1);
    chk("R4 tc wave", wave_o, 0);
    chk("R4 tc ready", ready_o, 1);
    ticks(1);
    stop_cmd(d);
    chk("R5 stop wave", wave_o, 1);
    chk("R5 stop ready", ready_o, 0);
    rd16(v);
    chk("R4 wrap", v, 16'hFFFF);
    ticks(3);
    rd16(v);
    chk("R5 halted", v, 16'hFFFF);
  endtask

  task automatic t_cnt_preload;
    logic [15:0] v;
    logic [7:0]  d;
    set_pre(16'h0010);
    start_cmd(d);
    ticks(2);
    set_pre(16'h0003);
    ticks(1);
    rd16(v);
    chk("R6 running unaffected", v, 16'h000D);
    stop_cmd(d);
    start_cmd(d);
    rd16(v);
    chk("R6 new start", v, 16'h0003);
    // same-cycle start and tick: start wins
    @(negedge clk_i);
    tick_i = 1'b1; re_i = 1'b1; addr_i = 3'd4;
    @(negedge clk_i);
    tick_i = 1'b0; re_i = 1'b0;
    rd16(v);
    chk("R11 start over tick", v, 16'h0003);
    repeat (4) @(negedge clk_i);
    rd16(v);
    chk("R11 no tick hold", v, 16'h0003);
    stop_cmd(d);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    logic [7:0]  d;
    set_pre(16'h0003);
    @(negedge clk_i);
    timer_i = 1'b1;
    start_cmd(d);
    chk("R7 start high", wave_o, 1);
    ticks(2);
    chk("R7 half not done", wave_o, 1);
    ticks(1);
    chk("R7 first toggle", wave_o, 0);
    chk("R7 no ready at half", ready_o, 0);
    ticks(3);
    chk("R7 second toggle", wave_o, 1);
    chk("R7 ready at period", ready_o, 1);
    rd16(v);
    chk("R10 count reads zero", v, 0);
    stop_cmd(d);
    chk("R8 stop clears ready", ready_o, 0);
    chk("R8 stop keeps wave", wave_o, 1);
    ticks(3);
    chk("R8 still running", wave_o, 0);
  endtask

  task automatic t_timer_reload;
    logic [7:0] d;
    start_cmd(d);
    ticks(1);
    set_pre(16'h0002);
    ticks(1);
    chk("R9 old half continues", wave_o, 1);
    ticks(1);
    chk("R9 old half ends", wave_o, 0);
    ticks(1);
    chk("R9 new half mid", wave_o, 0);
    ticks(1);
    chk("R9 new half ends", wave_o, 1);
    @(negedge clk_i);
    timer_i = 1'b0;
    stop_cmd(d);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_bytes();
    t_terminal();
    t_cnt_preload();
    t_timer();
    t_timer_reload();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule